// File: doc/BRIEF.md
# Posted Column Command Latency Scheduler

This block models the device-side latency timing of a double-data-rate SDRAM whose column commands may be posted early. It snoops the command bus and captures mode register loads: CAS latency (CL) from the main mode register, additive latency (AL) from the first extended register, and the high-temperature refresh-rate bit from the second extended register. Loads with reserved or out-of-range codes are rejected and flagged.

A READ or WRITE may be issued before the row-to-column delay has fully elapsed after ACTIVATE. The block delays each accepted column command by AL cycles and raises an internal-issue strobe at that point. It then raises a read-data-valid strobe at read latency AL+CL, or a write-data-expected strobe at write latency AL+CL-1. Several commands may be in flight at once. A column command that would reach the array before the row delay has passed, or that arrives before CL has been programmed, is dropped and flagged.

Top module: `cas_latency_sched`

## Requirements
- R1: `cmd_i` encodes 0 NOP, 1 mode load, 2 ACTIVATE, 3 READ and 4 WRITE, and codes 5 to 7 act as NOP. On a mode load, `ba_i` selects the target: 00 main register, 01 first extended, 10 second extended, 11 third extended. A load to the third extended register has no visible effect.
- R2: A load to the first extended register takes AL from `addr_i[5:3]`. Codes 0 to 4 that do not exceed T_RCD appear on `al_o` from the next cycle. Any other code pulses `mode_err_o` for one cycle in the next cycle and leaves `al_o` unchanged.
- R3: A load to the main register takes CL from `addr_i[6:4]`. Codes 3 to 5 appear on `cl_o` from the next cycle. Any other code pulses `mode_err_o` in the next cycle and leaves `cl_o` unchanged.
- R4: An accepted READ (WRITE) sampled in cycle c raises `rd_issue_o` (`wr_issue_o`) for one cycle in cycle c+AL. With AL = 0 this happens in cycle c itself.
- R5: An accepted READ in cycle c raises `rd_valid_o` in cycle c+AL+CL.
- R6: An accepted WRITE in cycle c raises `wr_expect_o` in cycle c+AL+CL-1.
- R7: A load to the second extended register copies `addr_i[7]` to `hts_o`. If any other address bit is set, the load is rejected with a `mode_err_o` pulse and `hts_o` keeps its value.
- R8: A column command in cycle c is accepted only if an ACTIVATE has been seen since reset and (c minus the cycle of the latest ACTIVATE) + AL >= T_RCD. Otherwise `timing_err_o` pulses in cycle c+1 and the command produces no strobe.
- R9: While CL holds no legal value, as after reset, every READ or WRITE is rejected as in R8.
- R10: Overlapping commands each produce their own strobes. The latencies in force when a command is sampled fix its strobe times, and a later mode load does not move them.
- R11: Reset (active low, asynchronous) clears AL, CL and the refresh-rate bit to zero, empties the pipelines, and holds every strobe and error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| ba_i | input | 2 | Bank address, mode register select on loads |
| addr_i | input | ADDR_W | Address / mode register value |
| rd_issue_o | output | 1 | READ issued internally |
| wr_issue_o | output | 1 | WRITE issued internally |
| rd_valid_o | output | 1 | Read data valid |
| wr_expect_o | output | 1 | Write data expected |
| al_o | output | 3 | Current additive latency |
| cl_o | output | 3 | Current CAS latency |
| hts_o | output | 1 | High-temperature refresh rate enabled |
| mode_err_o | output | 1 | Rejected mode load (one-cycle pulse) |
| timing_err_o | output | 1 | Rejected column command (one-cycle pulse) |

## Verification
Each result has a fixed due cycle. Issue strobes come AL cycles after the command, read-valid AL+CL cycles after it, and write-expected AL+CL-1 cycles after it. Both error pulses and the new register values appear one cycle after the command that caused them. When the bench drives a command, its model writes the expected strobe into a per-cycle table at the due cycle, using only the settings the model holds at that moment. A monitor compares every output with that table at the falling edge of each cycle, so a strobe one cycle early or late is reported, and so is a strobe that appears where none is due.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_MRS = 3'd1;
  localparam logic [2:0] CMD_ACT = 3'd2;
  localparam logic [2:0] CMD_RD  = 3'd3;
  localparam logic [2:0] CMD_WR  = 3'd4;

  localparam int AL_MAX  = 4;
  localparam int CL_MIN  = 3;
  localparam int CL_MAX  = 5;
  localparam int LAT_MAX = AL_MAX + CL_MAX;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);
endpackage

// File: rtl/cas_mode_regs.sv
module cas_mode_regs #(
  parameter int ADDR_W = 14,
  parameter int T_RCD  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        al_o,
  output logic [2:0]        cl_o,
  output logic              hts_o,
  output logic              cl_ok_o,
  output logic              mode_err_o
);
  import cas_pkg::*;

  localparam logic [ADDR_W-1:0] HTS_BIT = ADDR_W'(1) << 7;

  logic [2:0] al_q, cl_q;
  logic       hts_q, err_q;
  logic       al_bad, cl_bad, emr2_bad;

  assign al_bad   = int'(addr_i[5:3]) > AL_MAX || int'(addr_i[5:3]) > T_RCD;
  assign cl_bad   = int'(addr_i[6:4]) < CL_MIN || int'(addr_i[6:4]) > CL_MAX;
  assign emr2_bad = |(addr_i & ~HTS_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_q  <= '0;
      cl_q  <= '0;
      hts_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (load_i) begin
        unique case (ba_i)
          2'd0: if (cl_bad) err_q <= 1'b1; else cl_q <= addr_i[6:4];
          2'd1: if (al_bad) err_q <= 1'b1; else al_q <= addr_i[5:3];
          2'd2: if (emr2_bad) err_q <= 1'b1; else hts_q <= addr_i[7];
          default: ; // third extended register: accepted, no effect
        endcase
      end
    end
  end

  assign al_o       = al_q;
  assign cl_o       = cl_q;
  assign hts_o      = hts_q;
  assign mode_err_o = err_q;
  assign cl_ok_o    = int'(cl_q) >= CL_MIN;

  assert_hts_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ba_i == 2'd2 && addr_i == HTS_BIT |=> hts_o);
  assert_reject_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $stable(al_o) && $stable(cl_o) && $stable(hts_o));
endmodule

// File: rtl/cas_row_timer.sv
module cas_row_timer #(
  parameter int T_RCD = 4,
  localparam int CW   = $clog2(T_RCD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  output logic          open_o,
  output logic [CW-1:0] gap_o
);
  logic [CW-1:0] gap_q;
  logic          open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      open_q <= 1'b0;
    end else if (act_i) begin
      gap_q  <= CW'(1);
      open_q <= 1'b1;
    end else if (open_q && int'(gap_q) < T_RCD) begin
      gap_q <= gap_q + CW'(1);
    end
  end

  assign open_o = open_q;
  assign gap_o  = gap_q;

  assert_gap_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gap_o) <= T_RCD);
  assert_act_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o && gap_o == CW'(1));
endmodule

// File: rtl/cas_lat_pipe.sv
module cas_lat_pipe #(
  parameter int MAXL = 9,
  parameter int LW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [LW-1:0] lat_i,
  output logic          out_o
);
  logic [MAXL-1:0] sr_q, sr_d;

  // slot k fires k+1 cycles from now; a latency is dropped into its slot
  always_comb begin
    sr_d = {1'b0, sr_q[MAXL-1:1]};
    for (int i = 0; i < MAXL; i++)
      if (fire_i && int'(lat_i) == i + 1) sr_d[i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign out_o = sr_q[0] | (fire_i && lat_i == '0);

  assert_lat_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && lat_i == LW'(1) |=> out_o);
  assert_zero_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && lat_i == '0 |-> out_o);
endmodule

// File: rtl/cas_latency_sched.sv
module cas_latency_sched #(
  parameter int ADDR_W = 14,
  parameter int T_RCD  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_issue_o,
  output logic              wr_issue_o,
  output logic              rd_valid_o,
  output logic              wr_expect_o,
  output logic [2:0]        al_o,
  output logic [2:0]        cl_o,
  output logic              hts_o,
  output logic              mode_err_o,
  output logic              timing_err_o
);
  import cas_pkg::*;

  localparam int CW     = $clog2(T_RCD + 1);
  localparam int NPIPES = 4;

  logic          is_rd, is_wr, col, bad, cl_ok, row_open, terr_q;
  logic [CW-1:0] gap;
  logic [2:0]    al, cl;
  logic [LAT_W-1:0] rl, wl;
  logic [NPIPES-1:0] fire, strobe;
  logic [LAT_W-1:0]  lat [NPIPES];

  assign is_rd = cmd_i == CMD_RD;
  assign is_wr = cmd_i == CMD_WR;
  assign col   = is_rd | is_wr;

  cas_mode_regs #(.ADDR_W(ADDR_W), .T_RCD(T_RCD)) i_mode (
    .clk_i, .rst_ni,
    .load_i(cmd_i == CMD_MRS), .ba_i, .addr_i,
    .al_o(al), .cl_o(cl), .hts_o, .cl_ok_o(cl_ok), .mode_err_o
  );

  cas_row_timer #(.T_RCD(T_RCD)) i_row (
    .clk_i, .rst_ni, .act_i(cmd_i == CMD_ACT), .open_o(row_open), .gap_o(gap)
  );

  assign bad = col && (!cl_ok || !row_open || int'(gap) + int'(al) < T_RCD);
  assign rl  = LAT_W'(al) + LAT_W'(cl);
  assign wl  = rl - LAT_W'(1);

  assign fire = {is_wr && !bad, is_rd && !bad, is_wr && !bad, is_rd && !bad};
  assign lat[0] = LAT_W'(al);
  assign lat[1] = LAT_W'(al);
  assign lat[2] = rl;
  assign lat[3] = wl;

  for (genvar g = 0; g < NPIPES; g++) begin : g_pipe
    cas_lat_pipe #(.MAXL(LAT_MAX), .LW(LAT_W)) i_pipe (
      .clk_i, .rst_ni, .fire_i(fire[g]), .lat_i(lat[g]), .out_o(strobe[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) terr_q <= 1'b0;
    else         terr_q <= bad;
  end

  assign rd_issue_o   = strobe[0];
  assign wr_issue_o   = strobe[1];
  assign rd_valid_o   = strobe[2];
  assign wr_expect_o  = strobe[3];
  assign al_o         = al;
  assign cl_o         = cl;
  assign timing_err_o = terr_q;

  assert_al_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(al_o) <= AL_MAX);
  assert_cl_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_o == 3'd0 || (int'(cl_o) >= CL_MIN && int'(cl_o) <= CL_MAX));
  assert_no_open_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col && !row_open |=> timing_err_o);
  assert_unset_cl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col && cl_o == 3'd0 |=> timing_err_o);
endmodule

// File: tb/test_cas_latency_sched.sv
`timescale 1ns/1ps
module test_cas_latency_sched;
  localparam int ADDR_W = 14;
  localparam int T_RCD  = 4;
  localparam int NC     = 4096;

  logic clk = 1'b0, rst_ni = 1'b0, run = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] ba = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic rd_issue, wr_issue, rd_valid, wr_expect, hts, merr, terr;
  logic [2:0] al, cl;

  int cyc = 0, n_chk = 0, n_err = 0;
  bit e_rdi[NC], e_wri[NC], e_rdv[NC], e_wre[NC], e_merr[NC], e_terr[NC];
  int m_al = 0, m_cl = 0, m_hts = 0, m_act_cyc = 0;
  bit m_act = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cas_latency_sched #(.ADDR_W(ADDR_W), .T_RCD(T_RCD)) i_cas_latency_sched (
    .clk_i(clk), .rst_ni, .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .rd_issue_o(rd_issue), .wr_issue_o(wr_issue), .rd_valid_o(rd_valid),
    .wr_expect_o(wr_expect), .al_o(al), .cl_o(cl), .hts_o(hts),
    .mode_err_o(merr), .timing_err_o(terr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (run && rst_ni) begin
    chk("R4", "rd_issue", rd_issue, e_rdi[cyc]);
    chk("R4", "wr_issue", wr_issue, e_wri[cyc]);
    chk("R5", "rd_valid", rd_valid, e_rdv[cyc]);
    chk("R6", "wr_expect", wr_expect, e_wre[cyc]);
    chk("R2", "mode_err (R3 R7)", merr, e_merr[cyc]);
    chk("R8", "timing_err (R9)", terr, e_terr[cyc]);
    chk("R2", "al", al, m_al);
    chk("R3", "cl", cl, m_cl);
    chk("R7", "hts", hts, m_hts);
  end

  // drive one command in the current cycle, record its expected effects
  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic [ADDR_W-1:0] a);
    int c0 = cyc;
    int n_al = m_al, n_cl = m_cl, n_hts = m_hts;
    bit n_act = m_act;
    int n_act_cyc = m_act_cyc;
    cmd = c; ba = b; addr = a;
    if (c == 3'd1) begin
      if (b == 2'd0) begin
        if (a[6:4] >= 3 && a[6:4] <= 5) n_cl = a[6:4]; else e_merr[c0+1] = 1'b1;
      end else if (b == 2'd1) begin
        if (a[5:3] <= 4 && a[5:3] <= T_RCD) n_al = a[5:3]; else e_merr[c0+1] = 1'b1;
      end else if (b == 2'd2) begin
        if ((a & ~(ADDR_W'(1) << 7)) == 0) n_hts = a[7]; else e_merr[c0+1] = 1'b1;
      end
    end else if (c == 3'd2) begin
      n_act = 1'b1; n_act_cyc = c0;
    end else if (c == 3'd3 || c == 3'd4) begin
      if (m_cl >= 3 && m_act && (c0 - m_act_cyc) + m_al >= T_RCD) begin
        if (c == 3'd3) begin
          e_rdi[c0+m_al] = 1'b1; e_rdv[c0+m_al+m_cl] = 1'b1;
        end else begin
          e_wri[c0+m_al] = 1'b1; e_wre[c0+m_al+m_cl-1] = 1'b1;
        end
      end else e_terr[c0+1] = 1'b1;
    end
    @(posedge clk);
    m_al = n_al; m_cl = n_cl; m_hts = n_hts; m_act = n_act; m_act_cyc = n_act_cyc;
    #1;
    cmd = 3'd0; ba = 2'd0; addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 2'd0, '0);
  endtask

  initial begin
    for (int i = 0; i < 40000; i++) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset al", al, 0);
    chk("R11", "reset cl", cl, 0);
    chk("R11", "reset hts", hts, 0);
    chk("R11", "reset strobes", {rd_issue, wr_issue, rd_valid, wr_expect, merr, terr}, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1; run = 1'b1;

    // R9: no CL programmed yet
    step(3'd2, 2'd0, '0); idle(4);
    step(3'd3, 2'd0, '0); step(3'd4, 2'd0, '0); idle(2);
    // R3 / R2 / R7 / R1 mode loads, legal and rejected
    step(3'd1, 2'd0, ADDR_W'(7 << 4));
    step(3'd1, 2'd0, ADDR_W'(4 << 4));
    step(3'd1, 2'd1, ADDR_W'(5 << 3));
    step(3'd1, 2'd1, ADDR_W'(2 << 3));
    step(3'd1, 2'd2, ADDR_W'('h80));
    step(3'd1, 2'd2, ADDR_W'('h81));
    step(3'd1, 2'd3, ADDR_W'('h3fff));
    step(3'd5, 2'd0, '0); step(3'd7, 2'd1, '1);
    // R8: early by one cycle, then exactly at the limit; R10 back to back
    step(3'd2, 2'd0, '0);
    step(3'd3, 2'd0, '0);
    step(3'd3, 2'd0, '0);
    step(3'd4, 2'd0, '0);
    step(3'd3, 2'd0, '0);
    idle(12);
    // R4: AL = 0, issue in the same cycle
    step(3'd1, 2'd1, '0);
    step(3'd2, 2'd0, '0); idle(3);
    step(3'd3, 2'd0, '0); step(3'd4, 2'd0, '0); idle(2);
    // R10: latency change while a read is in flight
    step(3'd3, 2'd0, '0);
    step(3'd1, 2'd0, ADDR_W'(5 << 4));
    step(3'd3, 2'd0, '0); step(3'd4, 2'd0, '0);
    idle(12);

    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 50)      step(3'd0, 2'd0, '0);
      else if (r < 62) step(3'd2, 2'd0, '0);
      else if (r < 78) step(3'd3, 2'd0, '0);
      else if (r < 94) step(3'd4, 2'd0, '0);
      else begin
        logic [1:0] b = 2'($urandom_range(0, 3));
        logic [ADDR_W-1:0] a;
        if (b == 2'd0)      a = ADDR_W'($urandom_range(0, 7) << 4);
        else if (b == 2'd1) a = ADDR_W'($urandom_range(0, 7) << 3);
        else if (b == 2'd2) a = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(0, 1) << 7);
        else                a = ADDR_W'($urandom);
        step(3'd1, b, a);
      end
    end
    idle(12);
    run = 1'b0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule